// File: doc/BRIEF.md
# Corrected Error Counter with Threshold Alert

This block keeps a running tally of single-bit memory errors that were repaired on the fly by the ECC logic in front of a shared RAM. Two requesters read the RAM, a processor port and a DMA port, and each supplies a one-cycle strobe whenever one of its reads was corrected. The counter advances once per strobe. When the new value lands exactly on a software-programmed threshold, a sticky status flag is set, and an interrupt is raised if software has enabled it.

Software reaches four 32-bit registers through a simple write-strobe and combinational-read port: the count, the threshold, the interrupt enable and the status flag. Software may preload the count, including to a value equal to the threshold. That lets firmware rehearse the alert path, or arm it a fixed number of errors ahead.

Top module: `corr_err_counter`

## Requirements
- R1: After reset, the count, threshold, enable and flag all read zero and `irqOut` is low.
- R2: Register offsets on `regAddr` are 0 = count (bits 15:0), 1 = threshold (bits 15:0), 2 = enable (bit 0) and 3 = status flag (bit 0). All other read bits are zero, and written bits outside these fields are ignored.
- R3: Each cycle in which exactly one strobe is high adds one to the count, and the count wraps from 0xFFFF to 0x0000.
- R4: When both strobes are high in one cycle, the count advances by two, and the threshold is matched if either the +1 or the +2 value equals it.
- R5: A strobe-driven count that reaches the threshold sets the flag, whatever the enable bit holds.
- R6: A software write to the count of a value equal to the threshold sets the flag.
- R7: Matching is by equality only. Counts that move past the threshold without landing on it leave the flag unchanged.
- R8: The flag stays set until software writes 1 to status bit 0, and writing 0 there has no effect. If a match and a clear occur in the same cycle, the flag ends up set.
- R9: `irqOut` is high exactly when the flag is set and enable bit 0 is 1.
- R10: A software write to the count takes precedence over strobes in the same cycle, and those strobes are lost.
- R11: A threshold of zero is not matched by reset alone. It is matched by a wrap from 0xFFFF or by a software write of zero to the count.
- R12: A match is judged against the threshold held before the cycle, so a threshold write in the same cycle as a strobe does not take part in that cycle's comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuErrStrobe | input | 1 | Processor read was corrected this cycle |
| dmaErrStrobe | input | 1 | DMA read was corrected this cycle |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from `regAddr` |
| irqOut | output | 1 | Corrected-error interrupt |

## Verification
Several properties are checked on every cycle: single and double increments, the precedence of a count write over strobes, the threshold holding when it is not written, a match always leaving the flag set, and the flag staying set unless it is cleared. Some behaviours need whole scenarios from the bench and can only be shown there. These are the 0xFFFF wrap onto a zero threshold, the dual-strobe match on the +1 value and on the +2 value, the use of the old threshold when a write collides with a strobe, and the masking of the interrupt while the flag stays observable. A random mix of strobes, preloads and clears, kept close to small thresholds, is compared against a bench model.

// File: rtl/cec_pkg.sv
package cec_pkg;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] OFF_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] OFF_THRESH = 2'd1;
  localparam logic [ADDR_W-1:0] OFF_ENABLE = 2'd2;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 2'd3;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic loadCnt;    // software load of the count
    logic loadThr;    // software load of the threshold
    logic incFirst;   // at least one corrected error this cycle
    logic incSecond;  // a second corrected error this cycle
  } cecStrobes_t;
endpackage

// File: rtl/cec_ctrl.sv
module cec_ctrl
  import cec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuErr,
  input  logic              dmaErr,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrBit0,
  input  logic              matchHit,
  output cecStrobes_t       strobes,
  output logic              enableBit,
  output logic              flagBit,
  output logic              irqOut
);
  logic wrCount, wrThresh, wrEnable, clrFlag;

  always_comb begin
    wrCount  = regWrEn && (regAddr == OFF_COUNT);
    wrThresh = regWrEn && (regAddr == OFF_THRESH);
    wrEnable = regWrEn && (regAddr == OFF_ENABLE);
    clrFlag  = regWrEn && (regAddr == OFF_STATUS) && wrBit0;
  end

  // A software count write drops any increment in the same cycle
  always_comb begin
    strobes.loadCnt   = wrCount;
    strobes.loadThr   = wrThresh;
    strobes.incFirst  = (cpuErr || dmaErr) && !wrCount;
    strobes.incSecond = cpuErr && dmaErr && !wrCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableBit <= 1'b0;
      flagBit   <= 1'b0;
    end else begin
      if (wrEnable) enableBit <= wrBit0;
      if (matchHit)     flagBit <= 1'b1;
      else if (clrFlag) flagBit <= 1'b0;
    end
  end

  assign irqOut = flagBit && enableBit;

  // R5 / R6: any match leaves the flag set
  p_match_sets_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |=> flagBit);
  // R8: without a clear, the flag is sticky
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flagBit && !clrFlag) |=> flagBit);
  // R8: a flag that rises was caused by a match
  p_flag_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!flagBit && !matchHit) |=> !flagBit);
endmodule

// File: rtl/cec_datapath.sv
module cec_datapath
  import cec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cecStrobes_t      strobes,
  input  logic [CNT_W-1:0] wrValue,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] threshold,
  output logic             matchHit
);
  localparam logic [CNT_W-1:0] STEP_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] STEP_TWO = CNT_W'(2);

  logic [CNT_W-1:0] plusOne, plusTwo, nextCount;

  always_comb begin
    plusOne = count + STEP_ONE;
    plusTwo = count + STEP_TWO;
    if (strobes.loadCnt) begin
      nextCount = wrValue;
      matchHit  = (wrValue == threshold);
    end else begin
      nextCount = strobes.incSecond ? plusTwo : (strobes.incFirst ? plusOne : count);
      // Both intermediate values are compared so a +2 step cannot skip the threshold
      matchHit  = (strobes.incFirst  && (plusOne == threshold)) ||
                  (strobes.incSecond && (plusTwo == threshold));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      threshold <= '0;
    end else begin
      count <= nextCount;
      if (strobes.loadThr) threshold <= wrValue;
    end
  end

  // R3: a single error adds one, with wrap
  p_single_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.incFirst && !strobes.incSecond) |=> (count == $past(count) + STEP_ONE));
  // R4: two errors add two
  p_double_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incSecond |=> (count == $past(count) + STEP_TWO));
  // R10: a software load wins
  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCnt |=> (count == $past(wrValue)));
  // R12: the threshold only moves on its own write
  p_thr_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadThr |=> $stable(threshold));
endmodule

// File: rtl/corr_err_counter.sv
module corr_err_counter
  import cec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuErrStrobe,
  input  logic              dmaErrStrobe,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  localparam int PAD_W = DATA_W - CNT_W;

  cecStrobes_t      strobes;
  logic             matchHit, enableBit, flagBit;
  logic [CNT_W-1:0] count, threshold;
  logic             unusedHiBits;

  assign unusedHiBits = ^regWrData[DATA_W-1:CNT_W];

  cec_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cpuErr    (cpuErrStrobe),
    .dmaErr    (dmaErrStrobe),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .wrBit0    (regWrData[0]),
    .matchHit  (matchHit),
    .strobes   (strobes),
    .enableBit (enableBit),
    .flagBit   (flagBit),
    .irqOut    (irqOut)
  );

  cec_datapath uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrValue   (regWrData[CNT_W-1:0]),
    .count     (count),
    .threshold (threshold),
    .matchHit  (matchHit)
  );

  always_comb begin
    unique case (regAddr)
      OFF_COUNT:  regRdData = {{PAD_W{1'b0}}, count};
      OFF_THRESH: regRdData = {{PAD_W{1'b0}}, threshold};
      OFF_ENABLE: regRdData = {{(DATA_W-1){1'b0}}, enableBit};
      default:    regRdData = {{(DATA_W-1){1'b0}}, flagBit};
    endcase
  end
endmodule

// File: tb/corr_err_counter_test.sv
`timescale 1ns/100ps
module corr_err_counter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuErrStrobe = 1'b0, dmaErrStrobe = 1'b0, regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int checks = 0, fails = 0;
  string curTag = "R1";
  logic [15:0] mCnt = '0, mThr = '0;
  logic        mEn = 1'b0, mFlag = 1'b0;

  always #4 clk = ~clk;

  corr_err_counter uut (.*);

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Bench model: did this cycle produce a threshold match?
  function automatic logic modelHit(logic c, logic d, logic w, logic [1:0] a, logic [31:0] v);
    logic [15:0] one, two;
    one = mCnt + 16'd1;
    two = mCnt + 16'd2;
    if (w && a == 2'd0) return v[15:0] == mThr;
    return ((c || d) && one == mThr) || ((c && d) && two == mThr);
  endfunction

  function automatic logic [15:0] modelNext(logic c, logic d, logic w, logic [1:0] a, logic [31:0] v);
    if (w && a == 2'd0) return v[15:0];
    return mCnt + 16'(c) + 16'(d);
  endfunction

  task automatic checkAll();
    regAddr = 2'd0; #0.5 check(curTag, "count",   regRdData, {16'h0, mCnt});
    regAddr = 2'd1; #0.5 check(curTag, "thresh",  regRdData, {16'h0, mThr});
    regAddr = 2'd2; #0.5 check(curTag, "enable",  regRdData, {31'h0, mEn});
    regAddr = 2'd3; #0.5 check(curTag, "flag",    regRdData, {31'h0, mFlag});
    check(curTag, "irq R9", {31'h0, irqOut}, {31'h0, mFlag & mEn});
  endtask

  task automatic step(input logic c, input logic d, input logic w, input logic [1:0] a, input logic [31:0] v);
    logic hit;
    cpuErrStrobe = c; dmaErrStrobe = d; regWrEn = w; regAddr = a; regWrData = v;
    @(posedge clk);
    hit = modelHit(c, d, w, a, v);
    mCnt = modelNext(c, d, w, a, v);
    if (w && a == 2'd1) mThr = v[15:0];
    if (w && a == 2'd2) mEn = v[0];
    mFlag = hit | (mFlag & ~(w && a == 2'd3 && v[0]));
    @(negedge clk);
    cpuErrStrobe = 0; dmaErrStrobe = 0; regWrEn = 0;
    checkAll();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    step(0, 0, 1, a, v);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C3C));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curTag = "R1"; checkAll();
    // R11: zero threshold, idle after reset, no flag
    curTag = "R11"; step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    // R2: upper write bits ignored, upper read bits zero
    curTag = "R2"; wr(1, 32'hABCD_0005); wr(0, 32'hFFFF_0003); wr(2, 32'hFFFF_FFFE);
    // R5: reach threshold by strobes with enable off, R9: irq masked
    curTag = "R5"; step(1, 0, 0, 0, 0); step(0, 1, 0, 0, 0);
    curTag = "R9"; wr(2, 1); wr(2, 0); wr(2, 1);
    // R8: writing 0 keeps the flag, writing 1 clears it
    curTag = "R8"; wr(3, 0); wr(3, 1);
    // R7: moving past the threshold does not re-set the flag
    curTag = "R7"; step(1, 0, 0, 0, 0); step(1, 1, 0, 0, 0); step(0, 1, 0, 0, 0);
    // R8: match and clear in the same cycle leave the flag set
    curTag = "R8"; wr(0, 4); step(1, 0, 1, 3, 1); wr(3, 1);
    // R4: dual strobe matching the +1 value, then the +2 value
    curTag = "R4"; wr(0, 4); step(1, 1, 0, 0, 0); wr(3, 1); wr(0, 3); step(1, 1, 0, 0, 0); wr(3, 1);
    // R6: software load equal to threshold
    curTag = "R6"; wr(0, 5); wr(3, 1);
    // R10: load wins over both strobes
    curTag = "R10"; step(1, 1, 1, 0, 32'h0000_1234); step(1, 0, 1, 0, 32'h0000_0004);
    // R12: threshold written in the strobe cycle is not used that cycle
    curTag = "R12"; wr(0, 4); wr(1, 9); step(1, 0, 1, 1, 5);
    // R3 / R11: wrap from 0xFFFF onto a zero threshold
    curTag = "R3"; wr(3, 1); wr(1, 0); wr(0, 16'hFFFF); step(1, 0, 0, 0, 0);
    curTag = "R11"; wr(3, 1); wr(0, 0); wr(3, 1); wr(0, 16'hFFFE); step(1, 1, 0, 0, 0);
    // Random mix near small thresholds
    curTag = "R3";
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom_range(0, 9);
      logic c = 1'($urandom_range(0, 1));
      logic d = 1'($urandom_range(0, 1));
      if (sel == 0)      step(c, d, 1, 0, $urandom_range(0, 12) | 32'hA5A5_0000);
      else if (sel == 1) step(c, d, 1, 1, $urandom_range(0, 14));
      else if (sel == 2) step(c, d, 1, 2, $urandom);
      else if (sel == 3) step(c, d, 1, 3, $urandom);
      else               step(c, d, 0, 0, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule